// File: doc/BRIEF.md
# Amplifier Input Switch Selector

This block drives the switch matrix in front of an on-chip amplifier. The positive side has four candidate inputs and a calibration reference. The negative side has two pins, an internal gain-network tap, a follower short and the same reference. The block takes configuration fields and a timer compare signal. It produces one enable per switch, and each enable closes the switch it drives. It also produces a two-bit gain code for the resistor network.

Two selections are held in the configuration: a default one and a secondary one. In timer mode, the compare signal is first synchronized. The secondary selection then applies while the synchronized signal is high, and the default selection applies while it is low. Outside timer mode, only the default selection is used. There are two calibration overrides. The force bit places the reference on the positive side only. The calibration bit places the reference on both sides. Every change of switch state passes through one cycle in which all switches are open.

Top module: `amp_input_sel`

## Requirements
- R1: While reset is high, and in the first cycle after it, every switch enable is 0 and `gain_sel` is 0.
- R2: When `amp_en` is 0, every switch enable is 0 from the next clock edge onward. `gain_sel` is not affected.
- R3: The positive select value v (0..3) closes exactly `vp_on[v]`.
- R4: The 2-bit negative mode selects as follows: 00 closes `vm_on[0]`, 01 closes `vm_on[1]`, 10 closes `fb_on` (gain network tap), and 11 closes `fol_on` (follower).
- R5: In mode 10, `gain_code[3:2]` routes the network tap to a pin. 0x routes to no pin, 10 sets `mid_on[0]`, and 11 sets `mid_on[1]`. In any other mode, `mid_on` is 0.
- R6: `gain_sel` equals `gain_code[1:0]` from the previous clock edge. The codes 00, 01, 10 and 11 mean gains of x2, x4, x8 and x16.
- R7: When `tmux_en` is 0, the default fields apply whatever the level of `tmr_cmp`.
- R8: When `tmux_en` is 1, a high synchronized `tmr_cmp` applies `sec_vp` and `sec_vm` (0 = pin 0, 1 = pin 1), and a low one applies the default fields. A level change of `tmr_cmp` opens all switches after the third clock edge and closes the new set after the fourth.
- R9: `force_ref` closes `refp_on` and opens all of `vp_on`. The negative side still follows its selection.
- R10: `cal_en` closes `refp_on` and `refm_on` and opens every other switch. It overrides `force_ref` and all select fields.
- R11: When the wanted switch set differs from the current one and some switch is closed, all switches open for one cycle and the new set closes on the following edge. When every switch is already open, the new set closes on the next edge.
- R12: At most one positive-side switch (`vp_on`, `refp_on`) is closed at a time. At most one negative-side switch (`vm_on`, `fb_on`, `fol_on`, `refm_on`) is closed at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| amp_en | input | 1 | Amplifier enable; 0 opens all switches |
| tmux_en | input | 1 | Timer-driven selection enable |
| tmr_cmp | input | 1 | Asynchronous timer compare level |
| pri_vp | input | 2 | Default positive select |
| pri_vm | input | 2 | Default negative mode |
| sec_vp | input | 2 | Secondary positive select |
| sec_vm | input | 1 | Secondary negative pin |
| force_ref | input | 1 | Reference on positive side only |
| cal_en | input | 1 | Reference on both sides |
| gain_code | input | 4 | Gain code and tap routing |
| vp_on | output | 4 | Positive candidate switches |
| vm_on | output | 2 | Negative pin switches |
| fb_on | output | 1 | Gain network tap to negative input |
| fol_on | output | 1 | Output to negative input (follower) |
| refp_on | output | 1 | Reference to positive input |
| refm_on | output | 1 | Reference to negative input |
| mid_on | output | 2 | Gain network tap to negative pin 0/1 |
| gain_sel | output | 2 | Registered gain code |

## Verification
The hardest case to reach is the timer path. Its edge first crosses two synchronizer stages, then passes through the all-open cycle, so the new set appears only four edges after the edge of `tmr_cmp`. The stimulus sets up distinct default and secondary selections with the timer mode on. It then raises `tmr_cmp` between edges and samples after each of the following edges: it expects the old set after two edges, an open matrix after three, and the secondary set after four. A second directed sequence checks that a change from an all-open state skips the gap cycle.

// File: rtl/amp_sel_pkg.sv
package amp_sel_pkg;

    localparam int VP_NUM   = 4;
    localparam int VP_SEL_W = $clog2(VP_NUM);
    localparam int VM_PINS  = 2;
    localparam int VM_SEL_W = $clog2(VM_PINS);
    localparam int GAIN_W   = 4;
    localparam int GSEL_W   = 2;

    typedef enum logic [1:0] {
        VM_PIN0   = 2'b00,
        VM_PIN1   = 2'b01,
        VM_PGA    = 2'b10,
        VM_FOLLOW = 2'b11
    } vm_mode_e;

    typedef struct packed {
        logic [VP_NUM-1:0]  vp;
        logic [VM_PINS-1:0] vm;
        logic               fb;
        logic               fol;
        logic               refp;
        logic               refm;
        logic [VM_PINS-1:0] mid;
    } sw_t;

    localparam int SW_W = $bits(sw_t);

    typedef struct packed {
        logic [VP_SEL_W-1:0] vp;
        vm_mode_e            vm;
    } route_t;

    function automatic logic [VP_NUM-1:0] vp_onehot(input logic [VP_SEL_W-1:0] s);
        logic [VP_NUM-1:0] r;
        r = '0;
        for (int i = 0; i < VP_NUM; i++) begin
            if (s == VP_SEL_W'(i)) r[i] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [VM_PINS-1:0] pin_onehot(input logic [VM_SEL_W-1:0] s);
        logic [VM_PINS-1:0] r;
        r = '0;
        for (int i = 0; i < VM_PINS; i++) begin
            if (s == VM_SEL_W'(i)) r[i] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [VM_PINS-1:0] tap_route(input logic [1:0] hi);
        logic [VM_PINS-1:0] r;
        r = '0;
        if (hi[1]) r = pin_onehot(VM_SEL_W'(hi[0]));
        return r;
    endfunction

endpackage

// File: rtl/amp_tsync.sv
module amp_tsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/amp_route_dec.sv
module amp_route_dec
    import amp_sel_pkg::*;
(
    input  logic                amp_en,
    input  logic                cal_en,
    input  logic                force_ref,
    input  logic                sec_act,
    input  route_t              pri,
    input  logic [VP_SEL_W-1:0] sec_vp,
    input  logic [VM_SEL_W-1:0] sec_vm,
    input  logic [1:0]          tap_bits,
    output sw_t                 want
);
    route_t eff;

    always_comb begin
        if (sec_act) begin
            eff.vp = sec_vp;
            eff.vm = vm_mode_e'({1'b0, sec_vm});
        end else begin
            eff = pri;
        end
    end

    always_comb begin
        want = '0;
        if (amp_en) begin
            if (cal_en) begin
                want.refp = 1'b1;
                want.refm = 1'b1;
            end else begin
                if (force_ref) want.refp = 1'b1;
                else           want.vp   = vp_onehot(eff.vp);
                unique case (eff.vm)
                    VM_PIN0:   want.vm  = pin_onehot(VM_SEL_W'(0));
                    VM_PIN1:   want.vm  = pin_onehot(VM_SEL_W'(1));
                    VM_PGA: begin
                        want.fb  = 1'b1;
                        want.mid = tap_route(tap_bits);
                    end
                    VM_FOLLOW: want.fol = 1'b1;
                    default:   want.vm  = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/amp_bbm.sv
module amp_bbm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] want,
    output logic [W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (want != state) begin
            if (state == '0) state <= want;
            else             state <= '0;
        end
    end
endmodule

// File: rtl/amp_input_sel.sv
module amp_input_sel
    import amp_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                amp_en,
    input  logic                tmux_en,
    input  logic                tmr_cmp,
    input  logic [VP_SEL_W-1:0] pri_vp,
    input  logic [1:0]          pri_vm,
    input  logic [VP_SEL_W-1:0] sec_vp,
    input  logic [VM_SEL_W-1:0] sec_vm,
    input  logic                force_ref,
    input  logic                cal_en,
    input  logic [GAIN_W-1:0]   gain_code,
    output logic [VP_NUM-1:0]   vp_on,
    output logic [VM_PINS-1:0]  vm_on,
    output logic                fb_on,
    output logic                fol_on,
    output logic                refp_on,
    output logic                refm_on,
    output logic [VM_PINS-1:0]  mid_on,
    output logic [GSEL_W-1:0]   gain_sel
);
    logic        tmr_s;
    logic        sec_act;
    route_t      pri;
    sw_t         want;
    logic [SW_W-1:0] sw_q;
    sw_t         sw;
    logic [GSEL_W-1:0] gain_q;

    amp_tsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (tmr_cmp),
        .dout (tmr_s)
    );

    assign sec_act = tmux_en & tmr_s;
    assign pri.vp  = pri_vp;
    assign pri.vm  = vm_mode_e'(pri_vm);

    amp_route_dec u_dec (
        .amp_en    (amp_en),
        .cal_en    (cal_en),
        .force_ref (force_ref),
        .sec_act   (sec_act),
        .pri       (pri),
        .sec_vp    (sec_vp),
        .sec_vm    (sec_vm),
        .tap_bits  (gain_code[GAIN_W-1:GAIN_W-2]),
        .want      (want)
    );

    amp_bbm #(.W(SW_W)) u_bbm (
        .clk   (clk),
        .rst   (rst),
        .want  (want),
        .state (sw_q)
    );

    always_ff @(posedge clk) begin
        if (rst) gain_q <= '0;
        else     gain_q <= gain_code[GSEL_W-1:0];
    end

    assign sw       = sw_t'(sw_q);
    assign vp_on    = sw.vp;
    assign vm_on    = sw.vm;
    assign fb_on    = sw.fb;
    assign fol_on   = sw.fol;
    assign refp_on  = sw.refp;
    assign refm_on  = sw.refm;
    assign mid_on   = sw.mid;
    assign gain_sel = gain_q;
endmodule

// File: rtl/amp_input_sel_chk.sv
module amp_input_sel_chk
    import amp_sel_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                amp_en,
    input logic                force_ref,
    input logic                cal_en,
    input logic [GAIN_W-1:0]   gain_code,
    input logic [VP_NUM-1:0]   vp_on,
    input logic [VM_PINS-1:0]  vm_on,
    input logic                fb_on,
    input logic                fol_on,
    input logic                refp_on,
    input logic                refm_on,
    input logic [VM_PINS-1:0]  mid_on,
    input logic [GSEL_W-1:0]   gain_sel
);
    logic [SW_W-1:0] all_sw;
    logic            past_ok;

    assign all_sw = {vp_on, vm_on, fb_on, fol_on, refp_on, refm_on, mid_on};

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_RESET_OPEN: assert property (@(posedge clk) rst |=> all_sw == '0); // R1
    AST_DISABLE_OPEN: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(amp_en)) |-> all_sw == '0); // R2
    AST_TAP_NEEDS_FB: assert property (@(posedge clk) disable iff (rst)
        (mid_on != '0) |-> fb_on); // R5
    AST_GAIN_DELAY: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> gain_sel == $past(gain_code[GSEL_W-1:0])); // R6
    AST_FORCE_NO_EXT: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(amp_en && force_ref)) |-> vp_on == '0); // R9
    AST_CAL_ONLY_REF: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(amp_en && cal_en)) |->
        (vp_on == '0 && vm_on == '0 && !fb_on && !fol_on && mid_on == '0)); // R10
    AST_BREAK_GAP: assert property (@(posedge clk) disable iff (rst)
        (past_ok && all_sw != $past(all_sw)) |-> (all_sw == '0 || $past(all_sw) == '0)); // R11
    AST_POS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vp_on, refp_on})); // R12
    AST_NEG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vm_on, fb_on, fol_on, refm_on})); // R12
endmodule

bind amp_input_sel amp_input_sel_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .amp_en    (amp_en),
    .force_ref (force_ref),
    .cal_en    (cal_en),
    .gain_code (gain_code),
    .vp_on     (vp_on),
    .vm_on     (vm_on),
    .fb_on     (fb_on),
    .fol_on    (fol_on),
    .refp_on   (refp_on),
    .refm_on   (refm_on),
    .mid_on    (mid_on),
    .gain_sel  (gain_sel)
);

// File: tb/sim_amp_input_sel.sv
module sim_amp_input_sel;
    localparam int PERIOD = 10;
    localparam int NVEC   = 13;

    typedef struct packed {
        logic       en;
        logic       tm;
        logic       tr;
        logic [1:0] pvp;
        logic [1:0] pvm;
        logic [1:0] svp;
        logic       svm;
        logic       frc;
        logic       cal;
        logic [3:0] gc;
        logic [13:0] exp;   // {vp[4], vm[2], fb, fol, refp, refm, mid[2], gain[2]}
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{1'b1,1'b0,1'b0,2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,4'b0000,14'b0001_01_0000_00_00}, // R3 R4 pin0
        '{1'b1,1'b0,1'b0,2'd1,2'd1,2'd0,1'b0,1'b0,1'b0,4'b0000,14'b0010_10_0000_00_00}, // R3 R4 pin1
        '{1'b1,1'b0,1'b0,2'd2,2'd3,2'd0,1'b0,1'b0,1'b0,4'b0000,14'b0100_00_0100_00_00}, // R4 follower
        '{1'b1,1'b0,1'b0,2'd3,2'd2,2'd0,1'b0,1'b0,1'b0,4'b0001,14'b1000_00_1000_00_01}, // R5 R6 no tap
        '{1'b1,1'b0,1'b0,2'd3,2'd2,2'd0,1'b0,1'b0,1'b0,4'b1010,14'b1000_00_1000_01_10}, // R5 tap pin0
        '{1'b1,1'b0,1'b0,2'd3,2'd2,2'd0,1'b0,1'b0,1'b0,4'b1111,14'b1000_00_1000_10_11}, // R5 tap pin1
        '{1'b1,1'b0,1'b0,2'd3,2'd0,2'd0,1'b0,1'b0,1'b0,4'b1111,14'b1000_01_0000_00_11}, // R5 no tap off fb
        '{1'b1,1'b0,1'b1,2'd0,2'd0,2'd3,1'b1,1'b0,1'b0,4'b0000,14'b0001_01_0000_00_00}, // R7
        '{1'b1,1'b1,1'b1,2'd0,2'd0,2'd3,1'b1,1'b0,1'b0,4'b0000,14'b1000_10_0000_00_00}, // R8 secondary
        '{1'b1,1'b1,1'b0,2'd0,2'd0,2'd3,1'b1,1'b0,1'b0,4'b0000,14'b0001_01_0000_00_00}, // R8 default
        '{1'b1,1'b0,1'b0,2'd2,2'd1,2'd0,1'b0,1'b1,1'b0,4'b0000,14'b0000_10_0010_00_00}, // R9
        '{1'b1,1'b0,1'b0,2'd2,2'd1,2'd0,1'b0,1'b1,1'b1,4'b0000,14'b0000_00_0011_00_00}, // R10
        '{1'b0,1'b0,1'b0,2'd2,2'd1,2'd0,1'b0,1'b0,1'b0,4'b0000,14'b0000_00_0000_00_00}  // R2
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       amp_en = 1'b0, tmux_en = 1'b0, tmr_cmp = 1'b0;
    logic [1:0] pri_vp = '0, pri_vm = '0, sec_vp = '0;
    logic       sec_vm = 1'b0, force_ref = 1'b0, cal_en = 1'b0;
    logic [3:0] gain_code = '0;
    logic [3:0] vp_on;
    logic [1:0] vm_on, mid_on, gain_sel;
    logic       fb_on, fol_on, refp_on, refm_on;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    amp_input_sel u0 (
        .clk(clk), .rst(rst), .amp_en(amp_en), .tmux_en(tmux_en), .tmr_cmp(tmr_cmp),
        .pri_vp(pri_vp), .pri_vm(pri_vm), .sec_vp(sec_vp), .sec_vm(sec_vm),
        .force_ref(force_ref), .cal_en(cal_en), .gain_code(gain_code),
        .vp_on(vp_on), .vm_on(vm_on), .fb_on(fb_on), .fol_on(fol_on),
        .refp_on(refp_on), .refm_on(refm_on), .mid_on(mid_on), .gain_sel(gain_sel)
    );

    function automatic logic [13:0] obs();
        return {vp_on, vm_on, fb_on, fol_on, refp_on, refm_on, mid_on, gain_sel};
    endfunction

    task automatic check(input string req, input logic [13:0] exp);
        checks++;
        if (obs() !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, obs(), exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(input vec_t v);
        amp_en = v.en; tmux_en = v.tm; tmr_cmp = v.tr;
        pri_vp = v.pvp; pri_vm = v.pvm; sec_vp = v.svp; sec_vm = v.svm;
        force_ref = v.frc; cal_en = v.cal; gain_code = v.gc;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        amp_en = 1'b1; pri_vp = 2'd1; gain_code = 4'b0011;
        edges(3);
        check("R1 reset open", 14'b0);
        rst = 1'b0;
        // table walk; R12 one-hot per side is covered by the exact patterns
        for (int i = 0; i < NVEC; i++) begin
            apply(TBL[i]);
            edges(6);
            check($sformatf("vector %0d", i), TBL[i].exp);
        end
        // R11: from all-open, no gap cycle
        amp_en = 1'b1; pri_vp = 2'd0; pri_vm = 2'd0; force_ref = 1'b0; cal_en = 1'b0;
        edges(1);
        check("R11 direct from open", 14'b0001_01_0000_00_00);
        // R11: change while closed opens for one cycle
        pri_vp = 2'd1;
        edges(1);
        check("R11 gap cycle", 14'b0);
        edges(1);
        check("R11 new set", 14'b0010_01_0000_00_00);
        // R8: timer latency through the synchronizer and gap
        tmux_en = 1'b1; sec_vp = 2'd3; sec_vm = 1'b1; tmr_cmp = 1'b0;
        edges(6);
        check("R8 timer low default", 14'b0010_01_0000_00_00);
        tmr_cmp = 1'b1;
        edges(2);
        check("R8 still default after two edges", 14'b0010_01_0000_00_00);
        edges(1);
        check("R8 open after third edge", 14'b0);
        edges(1);
        check("R8 secondary after fourth edge", 14'b1000_10_0000_00_00);
        // R1: reset in mid-run opens everything and clears gain
        gain_code = 4'b0010;
        edges(2);
        rst = 1'b1;
        edges(1);
        check("R1 reset mid-run", 14'b0);
        rst = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule